// File: doc/BRIEF.md
# Multimatrix Binary Logic Processor

This block is a small SIMD engine for bit matrices. It holds four operand matrices, called units A to D, and one accumulating buffer matrix. All five matrices share one size of R rows by C columns. Each unit has exactly one logic operation tied to it. An instruction is a 2-bit opcode with a start strobe, and the opcode picks the unit, which also fixes the operation. The unit combines its matrix with the buffer and writes the result back into the buffer.

Three of the operations are AND, XOR and OR. Each works across the whole matrix in one cycle, with the unit matrix as the first operand and the buffer as the second. The fourth operation is shift-left-crowding. It reads only unit D. For each row it counts the ones and writes a row with that many ones packed against the most significant end. This operation runs one row per cycle.

Matrices enter through a row-wide load port that uses a valid/ready handshake. A row leaves the buffer through a combinational read port. A load offered while ld_ready is low is not taken. If the source keeps ld_valid high with the same row, the transfer completes on the first cycle in which ld_ready is high. The processor never drops a load that it has accepted.

Top module: `mmp_core`

## Requirements
- R1: Reset clears the buffer and all four unit matrices to zero, sets done low and sets ld_ready high.
- R2: A load transfers on a rising edge with ld_valid and ld_ready both high. It writes ld_data into row ld_row of the target named by ld_sel: 0 is unit A, 1 is unit B, 2 is unit C, 3 is unit D and 4 is the buffer.
- R3: A load with ld_sel equal to 5, 6 or 7 changes no matrix.
- R4: Accepting start with op 0, 1 or 2 replaces the buffer with A AND buffer, B XOR buffer or C OR buffer. The new buffer is visible, and done is high for one cycle, right after that edge.
- R5: Accepting start with op 3 begins shift-left-crowding. Done rises after the R-th following edge, and ld_ready stays low until then.
- R6: Shift-left-crowding sets buffer row r to a value whose k top bits (bit C-1 downward) are ones and whose remaining bits are zeros, where k is the number of ones in unit D row r.
- R7: ld_ready is low while start is high and while shift-left-crowding runs. A load held valid during that time is written only after ld_ready returns high.
- R8: A start pulse that arrives while shift-left-crowding runs is ignored. It does not change the buffer and does not produce an extra done.
- R9: rd_data always shows buffer row rd_row, with no cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load row offered |
| ld_ready | output | 1 | Load can be taken this cycle |
| ld_sel | input | 3 | Load target: 0 to 3 units A to D, 4 buffer |
| ld_row | input | $clog2(R) | Row index of the load |
| ld_data | input | C | Row contents of the load |
| op | input | 2 | Opcode: 0 AND, 1 XOR, 2 OR, 3 shift-left-crowding |
| start | input | 1 | Instruction strobe |
| done | output | 1 | One-cycle completion pulse |
| rd_row | input | $clog2(R) | Buffer row to read |
| rd_data | output | C | Buffer row contents |

## Verification
The assertions assume three things about the inputs: ld_row and rd_row stay below R, start is a level that is sampled each cycle, and a source offering a load keeps it stable until ld_ready is high. The stimulus meets these rules by changing inputs only on falling edges. Random row indices are drawn modulo R. A load is offered only while the engine is idle, except in the directed case that holds a load valid through a shift-left-crowding run. Random opcodes cover all four values, and the directed cases cover empty rows, full rows and single-bit rows for the crowding operation.

// File: rtl/mmp_pkg.sv
`timescale 1ns/1ps
package mmp_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'd0,
    OP_XOR = 2'd1,
    OP_OR  = 2'd2,
    OP_SLC = 2'd3
  } mmp_op_e;

  localparam int NUM_UNITS = 4;
  localparam logic [2:0] SEL_BUF = 3'd4;
endpackage

// File: rtl/mmp_store.sv
`timescale 1ns/1ps
// One operand matrix with a row-wide write port and full parallel view.
module mmp_store #(
  parameter int R = 8,
  parameter int C = 16,
  localparam int RW = $clog2(R)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [RW-1:0]         waddr,
  input  logic [C-1:0]          wdata,
  output logic [R-1:0][C-1:0]   q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (we) q[waddr] <= wdata;
  end
endmodule

// File: rtl/mmp_slc_row.sv
`timescale 1ns/1ps
// Packs the ones of one row against the MSB end.
module mmp_slc_row #(
  parameter int C = 16,
  localparam int CW = $clog2(C + 1)
) (
  input  logic [C-1:0] din,
  output logic [C-1:0] dout
);
  logic [CW-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < C; i++) ones = ones + CW'(din[i]);
    dout = ~({C{1'b1}} >> ones);
  end

  always_comb begin
    if (!$isunknown(din))
      AST_SLC_COUNT_KEPT: assert ($countones(dout) == $countones(din)); // R6
  end
endmodule

// File: rtl/mmp_ctrl.sv
`timescale 1ns/1ps
// Sequencer: single-cycle logic ops, row-serial crowding.
module mmp_ctrl
  import mmp_pkg::*;
#(
  parameter int R = 8,
  localparam int RW = $clog2(R)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  mmp_op_e       op,
  output logic          idle,
  output logic          go_logic,
  output logic          slc_on,
  output logic [RW-1:0] slc_row,
  output logic          done
);
  typedef enum logic {ST_IDLE, ST_SLC} st_e;
  st_e st;

  assign idle     = (st == ST_IDLE);
  assign slc_on   = (st == ST_SLC);
  assign go_logic = idle && start && (op != OP_SLC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      slc_row <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          if (op == OP_SLC) begin
            st      <= ST_SLC;
            slc_row <= '0;
          end else begin
            done <= 1'b1;
          end
        end
        ST_SLC: begin
          slc_row <= slc_row + 1'b1;
          if (slc_row == RW'(R - 1)) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_LOGIC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && op != OP_SLC) |=> (done && idle)); // R4
  AST_SLC_STAYS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (slc_on && slc_row != RW'(R - 1)) |=> (!idle && !done)); // R5
  AST_SLC_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (slc_on && slc_row == RW'(R - 1)) |=> (done && idle)); // R5
endmodule

// File: rtl/mmp_core.sv
`timescale 1ns/1ps
module mmp_core
  import mmp_pkg::*;
#(
  parameter int R = 8,
  parameter int C = 16,
  localparam int RW = $clog2(R)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [2:0]    ld_sel,
  input  logic [RW-1:0] ld_row,
  input  logic [C-1:0]  ld_data,
  input  logic [1:0]    op,
  input  logic          start,
  output logic          done,
  input  logic [RW-1:0] rd_row,
  output logic [C-1:0]  rd_data
);
  logic                idle, go_logic, slc_on, ld_fire;
  logic [RW-1:0]       slc_row;
  logic [C-1:0]        slc_out;
  logic [R-1:0][C-1:0] umat [NUM_UNITS];
  logic [R-1:0][C-1:0] buf_q;
  mmp_op_e             op_e;

  assign op_e     = mmp_op_e'(op);
  assign ld_ready = idle && !start;
  assign ld_fire  = ld_valid && ld_ready;

  mmp_ctrl #(.R(R)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op_e), .idle(idle),
    .go_logic(go_logic), .slc_on(slc_on), .slc_row(slc_row), .done(done)
  );

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    mmp_store #(.R(R), .C(C)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we(ld_fire && ld_sel == 3'(u)),
      .waddr(ld_row), .wdata(ld_data), .q(umat[u])
    );
  end

  mmp_slc_row #(.C(C)) u_slc (.din(umat[3][slc_row]), .dout(slc_out));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (go_logic) begin
      case (op_e)
        OP_AND:  buf_q <= umat[0] & buf_q;
        OP_XOR:  buf_q <= umat[1] ^ buf_q;
        OP_OR:   buf_q <= umat[2] | buf_q;
        default: buf_q <= buf_q;
      endcase
    end
    else if (slc_on) buf_q[slc_row] <= slc_out;
    else if (ld_fire && ld_sel == SEL_BUF) buf_q[ld_row] <= ld_data;
  end

  assign rd_data = buf_q[rd_row];

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (go_logic && op_e == OP_AND) |=> (buf_q == $past(umat[0] & buf_q))); // R4
  AST_BAD_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fire && ld_sel > SEL_BUF) |=> $stable(buf_q)); // R3
  AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (slc_on || start) |-> !ld_ready); // R7
endmodule

// File: tb/mmp_core_test.sv
`timescale 1ns/1ps
module mmp_core_test;
  localparam int R  = 8;
  localparam int C  = 16;
  localparam int RW = $clog2(R);

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, start = 0;
  logic ld_ready, done;
  logic [2:0] ld_sel = 0;
  logic [RW-1:0] ld_row = 0, rd_row = 0;
  logic [C-1:0] ld_data = 0, rd_data;
  logic [1:0] op = 0;

  int checks = 0, errs = 0;
  bit finished = 0;
  logic [C-1:0] um [4][R];
  logic [C-1:0] bm [R];

  always #4 clk = ~clk;

  mmp_core #(.R(R), .C(C)) uut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_row(ld_row), .ld_data(ld_data), .op(op),
    .start(start), .done(done), .rd_row(rd_row), .rd_data(rd_data)
  );

  function automatic logic [C-1:0] crowd(input logic [C-1:0] v);
    int k = 0;
    logic [C-1:0] r = '0;
    for (int i = 0; i < C; i++) if (v[i]) k++;
    for (int i = 0; i < k; i++) r[C-1-i] = 1'b1;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [C-1:0] act, input logic [C-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_buf(input string tag);
    for (int r = 0; r < R; r++) begin
      rd_row = RW'(r);
      #1;
      chk(tag, rd_data, bm[r]);
    end
  endtask

  task automatic do_load(input int sel, input int row, input logic [C-1:0] d);
    ld_valid = 1; ld_sel = 3'(sel); ld_row = RW'(row); ld_data = d;
    @(posedge clk); @(negedge clk);
    ld_valid = 0;
    if (sel < 4) um[sel][row] = d;
    else if (sel == 4) bm[row] = d;
  endtask

  task automatic do_op(input int o);
    start = 1; op = 2'(o);
    @(posedge clk); @(negedge clk);
    start = 0;
    if (o < 3) begin
      chk("R4 done", C'(done), C'(1));
      for (int r = 0; r < R; r++)
        bm[r] = (o == 0) ? (um[0][r] & bm[r]) : (o == 1) ? (um[1][r] ^ bm[r]) : (um[2][r] | bm[r]);
      check_buf("R4 result");
    end else begin
      chk("R5 ready low", C'(ld_ready), C'(0));
      for (int i = 1; i <= R; i++) begin
        @(posedge clk); @(negedge clk);
        if (i == R) chk("R5 done", C'(done), C'(1));
      end
      for (int r = 0; r < R; r++) bm[r] = crowd(um[3][r]);
      check_buf("R6 crowd");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int u = 0; u < 4; u++) for (int r = 0; r < R; r++) um[u][r] = '0;
    for (int r = 0; r < R; r++) bm[r] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", C'(done), C'(0));
    chk("R1 ready", C'(ld_ready), C'(1));
    check_buf("R1 buffer");
    for (int r = 0; r < R; r++) do_load(4, r, C'(16'hF0F0 ^ r));
    do_op(2); do_op(1);   // R1: zero units C and B leave buffer unchanged
    do_op(0);             // R1: zero unit A clears buffer
    do_op(3);             // R1: zero unit D gives zero rows
    // R2 loads, R4 each logic op
    for (int u = 0; u < 3; u++) for (int r = 0; r < R; r++) do_load(u, r, C'($urandom));
    for (int r = 0; r < R; r++) do_load(4, r, C'($urandom));
    do_op(2); do_op(1); do_op(0);
    rd_row = 3; #1;
    chk("R9 read", rd_data, bm[3]);
    // R3 invalid selects
    do_load(5, 1, 16'hFFFF); do_load(6, 2, 16'hFFFF); do_load(7, 3, 16'hFFFF);
    check_buf("R3 buffer");
    do_op(1); do_op(2); do_op(0);
    // R6 corner rows
    do_load(3, 0, 16'h0000); do_load(3, 1, 16'hFFFF); do_load(3, 2, 16'h0001);
    do_load(3, 3, 16'h8000); do_load(3, 4, 16'h5555); do_load(3, 5, 16'h7FFF);
    do_load(3, 6, 16'h0100); do_load(3, 7, 16'hC003);
    do_op(3);
    // R7 and R8: held load and stray start during crowding
    do_load(0, 0, 16'h0000);
    start = 1; op = 2'd3;
    @(posedge clk); @(negedge clk);
    ld_valid = 1; ld_sel = 3'd4; ld_row = 2; ld_data = 16'hA5A5;
    op = 2'd0;
    chk("R7 ready low", C'(ld_ready), C'(0));
    for (int i = 1; i <= R; i++) begin
      @(posedge clk); @(negedge clk);
      start = 0;
      if (i == R) begin
        chk("R5 done", C'(done), C'(1));
        rd_row = 2; #1;
        chk("R7 held not yet written", rd_data, crowd(um[3][2]));
      end
    end
    @(posedge clk); @(negedge clk);
    ld_valid = 0;
    chk("R8 no extra done", C'(done), C'(0));
    for (int r = 0; r < R; r++) bm[r] = crowd(um[3][r]);
    bm[2] = 16'hA5A5;
    check_buf("R8 buffer");
    // random mix
    for (int it = 0; it < 40; it++) begin
      int n = 1 + int'($urandom % 5);
      for (int j = 0; j < n; j++)
        do_load(int'($urandom % 6), int'($urandom % R), C'($urandom));
      do_op(int'($urandom % 4));
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule